// File: doc/BRIEF.md
# Masked GPIO Output Bank with Per-Pin Change Events

This block drives sixteen general-purpose output pins from two sets of byte-wide registers on a small register bus. One set holds the data value of each pin and the other holds its output enable. The level the block presents for a pin is its data bit gated by its enable bit, so a pin that is not enabled always reads as low on the output vector.

Whenever a register write changes any bit of that gated level, the block raises a one-clock strobe on every pin whose level moved. The new level of each strobed pin is on the output vector in the same cycle. A consumer that tracks pin changes only has to watch the strobes and sample the level vector when one is high. A change can come from a data write, an enable write, or both in turn; each one is reported against the level reported last.

Reads are combinational: the byte for the current offset appears on the read data port in the same cycle. Each register family has three byte lanes. The third lane of each family is stored and can be read back, but no pin sits behind it.

Top module: `gpio_out_events`

## Requirements
- R1: Data byte lane k sits at offset 0x78+k (k = 0..2). Bit j of lane k is the data bit of pin 8k+j.
- R2: Enable byte lane k sits at offset 0x7C+k, with the same bit-to-pin mapping as the data lanes.
- R3: While `offset` addresses a data or enable lane, `rdata` shows the byte stored there in the same cycle. Every other offset reads as 0x00.
- R4: `pin_out[i]` equals data bit i AND enable bit i. It takes the value written on the clock edge that samples the write.
- R5: On the edge that samples a write, `chg_stb[i]` goes high for each pin whose gated level differs from the level reported before. It stays high for exactly that one cycle unless a further write changes the pin again.
- R6: A write that leaves every gated level unchanged produces no strobe. Examples are data bits written under a cleared enable, or enable bits set while the data is 0.
- R7: Bytes written to the third lane (offsets 0x7A and 0x7E) can be read back but change no pin and raise no strobe.
- R8: Reset clears all data, enable and reported levels, so `pin_out`, `chg_stb` and every stored byte read 0.
- R9: A write to an offset outside the six lanes changes no stored byte, no pin and no strobe.
- R10: Several pins may strobe in the same cycle when one write moves more than one gated level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the byte at `offset` |
| offset | input | 8 | Register byte offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `offset`, combinational |
| pin_out | output | 16 | Gated pin levels (data AND enable) |
| chg_stb | output | 16 | One-cycle change strobe per pin |

## Verification
Read data depends only on the stored bytes and the current offset. It is due in the same cycle, so the bench sets the offset just after a falling edge and samples `rdata` one nanosecond later. Pin levels and strobes come from one register stage and are due on the rising edge that samples the write. The driver pushes the expected pair for each cycle it drives at the falling edge before that rising edge. The monitor pops the pair and compares it two nanoseconds after the rising edge, so every write, idle cycle and read gets its own slot. This also shows that strobes drop again after one cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int NUM_PINS = 16;
    localparam int BYTE_W   = 8;
    localparam int LANES    = 3;
    localparam int OFS_W    = 8;
    localparam int BANK_W   = LANES * BYTE_W;
    localparam logic [OFS_W-1:0] DATA_BASE = 8'h78;
    localparam logic [OFS_W-1:0] EN_BASE   = 8'h7C;

    typedef struct packed {
        logic [BANK_W-1:0] data;
        logic [BANK_W-1:0] en;
    } bank_t;

    typedef struct packed {
        logic [NUM_PINS-1:0] lvl;
        logic [NUM_PINS-1:0] stb;
    } trk_t;
endpackage

// File: rtl/gpio_evt_regfile.sv
module gpio_evt_regfile
    import gpio_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [OFS_W-1:0]    offset,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    output logic [NUM_PINS-1:0] data_nxt,
    output logic [NUM_PINS-1:0] en_nxt,
    output logic [NUM_PINS-1:0] data_cur,
    output logic [NUM_PINS-1:0] en_cur
);
    bank_t bank_d, bank_q;
    logic [LANES-1:0] data_hit;
    logic [LANES-1:0] en_hit;

    // Per-lane address decode
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign data_hit[k] = (offset == DATA_BASE + OFS_W'(k));
        assign en_hit[k]   = (offset == EN_BASE + OFS_W'(k));
    end

    always_comb begin
        bank_d = bank_q;
        rdata  = '0;
        for (int k = 0; k < LANES; k++) begin
            if (wr_en && data_hit[k]) bank_d.data[k*BYTE_W +: BYTE_W] = wdata;
            if (wr_en && en_hit[k])   bank_d.en[k*BYTE_W +: BYTE_W]   = wdata;
            if (data_hit[k]) rdata = bank_q.data[k*BYTE_W +: BYTE_W];
            if (en_hit[k])   rdata = bank_q.en[k*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign data_nxt = bank_d.data[NUM_PINS-1:0];
    assign en_nxt   = bank_d.en[NUM_PINS-1:0];
    assign data_cur = bank_q.data[NUM_PINS-1:0];
    assign en_cur   = bank_q.en[NUM_PINS-1:0];

    AST_DATA_LANE0_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == DATA_BASE) |=> (rdata == $past(wdata) || offset != DATA_BASE)); // R3
    AST_UNMAPPED_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && data_hit == '0 && en_hit == '0) |=> ($stable(data_cur) && $stable(en_cur))); // R9
endmodule

// File: rtl/gpio_evt_tracker.sv
module gpio_evt_tracker
    import gpio_evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] data_nxt,
    input  logic [NUM_PINS-1:0] en_nxt,
    output logic [NUM_PINS-1:0] lvl_q,
    output logic [NUM_PINS-1:0] stb_q
);
    trk_t trk_d, trk_q;
    logic [NUM_PINS-1:0] eff;

    always_comb begin
        eff       = data_nxt & en_nxt;
        trk_d.lvl = eff;
        trk_d.stb = eff ^ trk_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign lvl_q = trk_q.lvl;
    assign stb_q = trk_q.stb;

    AST_STB_MARKS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stb_q == (lvl_q ^ $past(lvl_q)))); // R5
endmodule

// File: rtl/gpio_out_events.sv
module gpio_out_events
    import gpio_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  offset,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic [15:0] pin_out,
    output logic [15:0] chg_stb
);
    logic [NUM_PINS-1:0] data_nxt, en_nxt, data_cur, en_cur;

    gpio_evt_regfile u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .offset   (offset),
        .wdata    (wdata),
        .rdata    (rdata),
        .data_nxt (data_nxt),
        .en_nxt   (en_nxt),
        .data_cur (data_cur),
        .en_cur   (en_cur)
    );

    gpio_evt_tracker u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_nxt (data_nxt),
        .en_nxt   (en_nxt),
        .lvl_q    (pin_out),
        .stb_q    (chg_stb)
    );

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pin_out == (data_cur & en_cur)); // R4
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (chg_stb == '0)); // R6
    AST_LANE2_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (offset == DATA_BASE + 8'd2 || offset == EN_BASE + 8'd2)) |=> (chg_stb == '0)); // R7
endmodule

// File: tb/gpio_out_events_bench.sv
module gpio_out_events_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  offset = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] pin_out, chg_stb;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [15:0] pins;
        logic [15:0] stb;
        string       req;
    } exp_t;
    exp_t scb[$];

    logic [23:0] m_data = '0;
    logic [23:0] m_en   = '0;
    logic [15:0] m_prev = '0;

    always #5 clk = ~clk;

    gpio_out_events u_gpio_out_events (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .offset(offset),
        .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .chg_stb(chg_stb)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic push(input string req);
        logic [15:0] eff;
        exp_t it;
        eff = m_data[15:0] & m_en[15:0];
        it.pins = eff;
        it.stb  = eff ^ m_prev;
        it.req  = req;
        m_prev  = eff;
        scb.push_back(it);
    endtask

    task automatic wr(input logic [7:0] ofs, input logic [7:0] val, input string req);
        @(negedge clk);
        wr_en = 1'b1; offset = ofs; wdata = val;
        for (int k = 0; k < 3; k++) begin
            if (ofs == 8'h78 + 8'(k)) m_data[k*8 +: 8] = val;
            if (ofs == 8'h7C + 8'(k)) m_en[k*8 +: 8]   = val;
        end
        push(req);
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        wr_en = 1'b0;
        push(req);
    endtask

    task automatic rd(input logic [7:0] ofs, input logic [7:0] exp, input string req);
        @(negedge clk);
        wr_en = 1'b0; offset = ofs;
        push(req);
        #1;
        check(rdata == exp, req, {8'h00, rdata}, {8'h00, exp});
    endtask

    // Monitor: compares the result of the edge that sampled each driven cycle
    always @(posedge clk) begin
        #2;
        if (rst_n && scb.size() > 0) begin
            exp_t it;
            it = scb.pop_front();
            check(pin_out == it.pins, {it.req, " level"}, pin_out, it.pins);
            check(chg_stb == it.stb, {it.req, " strobe"}, chg_stb, it.stb);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        offset = 8'h78;
        #1;
        check(pin_out == 16'h0 && chg_stb == 16'h0, "R8 reset outputs", pin_out | chg_stb, 16'h0);
        check(rdata == 8'h00, "R8 reset data byte", {8'h00, rdata}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R8 no event after reset");
        rd(8'h7C, 8'h00, "R8 reset enable byte");

        wr(8'h78, 8'hA5, "R6 data under cleared enable");
        rd(8'h78, 8'hA5, "R3 data lane 0 readback");
        wr(8'h7C, 8'hFF, "R2 R10 enable lane 0 exposes data");
        wr(8'h79, 8'h3C, "R6 R1 data lane 1 under cleared enable");
        wr(8'h7D, 8'h0F, "R2 enable lane 1 low nibble");
        wr(8'h7C, 8'h0F, "R5 enable clear drops pins");
        idle("R5 strobe lasts one cycle");
        rd(8'h7D, 8'h0F, "R3 enable lane 1 readback");

        wr(8'h7A, 8'hFF, "R7 data lane 2");
        wr(8'h7E, 8'hFF, "R7 enable lane 2");
        rd(8'h7A, 8'hFF, "R7 data lane 2 readback");
        rd(8'h7E, 8'hFF, "R7 enable lane 2 readback");

        wr(8'h40, 8'hFF, "R9 unmapped write");
        wr(8'h7B, 8'hFF, "R9 gap offset write");
        rd(8'h40, 8'h00, "R9 unmapped reads zero");
        rd(8'h7B, 8'h00, "R9 gap reads zero");
        rd(8'h78, 8'hA5, "R9 data lane 0 kept");

        wr(8'h78, 8'h5A, "R10 R4 several pins toggle");
        wr(8'h78, 8'h5A, "R6 same value rewrite");
        wr(8'h79, 8'h00, "R1 data lane 1 cleared");
        wr(8'h79, 8'hFF, "R1 R5 back to back lane 1");
        wr(8'h7D, 8'hF0, "R2 R10 enable swap upper pins");
        wr(8'h7C, 8'h00, "R4 all lower pins disabled");
        wr(8'h7D, 8'h00, "R4 all pins disabled");
        wr(8'h78, 8'hFF, "R6 data write while disabled");
        idle("R5 quiet after writes");
        idle("R5 quiet second cycle");
        rd(8'h78, 8'hFF, "R3 final data readback");

        repeat (2) @(negedge clk);
        check(scb.size() == 0, "R5 all results seen", 16'(scb.size()), 16'h0);
        finish_run();
    end
endmodule